// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small CPU sequencer and decides, at each instruction boundary, whether an interrupt is to be taken and where execution must go. It watches five request inputs: a non-maskable trap, three maskable restart requests at levels 7.5, 6.5 and 5.5, and a general external request. It combines them with per-level masks and a global enable, and raises a one-cycle take pulse. The pulse comes with a 16-bit vector address, which is the level times eight. For the general request it instead asserts an active-low acknowledge strobe and flags that the vector must be supplied from outside.

Software controls the block through a mask-write word and reads it back through a status word. The mask-write word can load the three restart masks, discard a latched 7.5 request and drive a serial output pin. The status word returns the masks, the enable, the raw restart request state and a serial input bit. The enable-interrupts command only opens the gate after the instruction that follows it has completed. Accepting any interrupt closes the gate again.

Top module: `intvec_ctrl`

## Requirements
- R1: Vector addresses are level times eight: trap (level 4.5) gives 0024H, level 7.5 gives 003CH, level 6.5 gives 0034H and level 5.5 gives 002CH.
- R2: When several requests are eligible at one boundary, the winner is, from highest to lowest: trap, 7.5, 6.5, 5.5, general request.
- R3: Mask-write word bit 0 masks 5.5, bit 1 masks 6.5 and bit 2 masks 7.5 (1 = masked). These bits are loaded only when bit 3 is 1. Masks reset to all ones, and the trap ignores them.
- R4: The trap is taken only if a rising edge was seen and the input is still high at the boundary. A trap held high is taken once per rising edge.
- R5: A rising edge on 7.5 is latched and stays pending after the input falls. The latch is cleared when 7.5 is accepted, or by a mask write with bit 4 set.
- R6: Levels 6.5 and 5.5 are level-sensitive: a request that has dropped before the boundary is not taken.
- R7: A boundary reported together with the enable command cannot take a maskable request. The next boundary can.
- R8: Accepting any interrupt clears the global enable, and the disable command clears it too. The trap is taken even with the enable clear.
- R9: When the general request wins, the vector is 0000H, the external-vector flag is 1 and the active-low acknowledge is 0 for exactly the take cycle. The acknowledge is 1 at all other times.
- R10: A take is signalled by take_o high for one cycle, in the cycle after the instr_done boundary, with the vector registered alongside.
- R11: The serial output pin loads mask-write bit 6 only when bit 7 is 1, and holds otherwise. It resets to 0.
- R12: One cycle after stat_rd, status_o holds: bit 7 serial input, bit 6 latched 7.5 request, bit 5 raw 6.5 input, bit 4 raw 5.5 input, bit 3 global enable, bits 2:0 the masks as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Non-maskable trap request |
| req75 | input | 1 | Restart 7.5 request, rising-edge captured |
| req65 | input | 1 | Restart 6.5 request, level |
| req55 | input | 1 | Restart 5.5 request, level |
| ext_req | input | 1 | General request with external vector |
| instr_done | input | 1 | Instruction boundary pulse from the sequencer |
| ei_cmd | input | 1 | Enable-interrupts command |
| di_cmd | input | 1 | Disable-interrupts command |
| mask_wr | input | 1 | Mask-write strobe |
| mask_wdata | input | 8 | Mask-write word |
| stat_rd | input | 1 | Status-read strobe |
| serial_in | input | 1 | Serial input data bit |
| take_o | output | 1 | Take-interrupt pulse |
| vector_o | output | 16 | Vector address of the accepted request |
| vec_ext_o | output | 1 | Vector must come from outside |
| inta_n_o | output | 1 | Active-low acknowledge for the general request |
| serial_out_o | output | 1 | Serial output data pin |
| status_o | output | 8 | Status word |

## Verification
The bench attacks the enable delay directly. It reports a boundary together with the enable command while a request is waiting. A design that opens the gate immediately would take it one instruction early. It also pulses 7.5 and drops it before the boundary, where a level-sensitive design would lose the request. It then checks that the latch is cleared by accept and by the clear bit, since a sticky latch would re-enter the handler. For the trap, the bench drops the input before the boundary and then holds it high across two boundaries. A design keyed only on the edge or only on the level would take it wrongly in one of those cases. The table also crosses masks against all request combinations, so a swapped mask bit or a wrong priority shows up as the wrong vector.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

  localparam int NSRC   = 5;
  localparam int VEC_W  = 16;
  localparam int WORD_W = 8;
  localparam int MASK_W = 3;

  // Source index doubles as priority rank: lower index wins.
  localparam int SRC_TRAP = 0;
  localparam int SRC_R75  = 1;
  localparam int SRC_R65  = 2;
  localparam int SRC_R55  = 3;
  localparam int SRC_GEN  = 4;

  // Mask-write word field positions.
  localparam int MW_MSE   = 3;
  localparam int MW_CLR75 = 4;
  localparam int MW_SDO   = 6;
  localparam int MW_SDE   = 7;

  // Level in half steps (4.5 -> 9); vector = level * 8 = half_steps * 4.
  function automatic int half_steps(input int idx);
    case (idx)
      SRC_TRAP: return 9;
      SRC_R75:  return 15;
      SRC_R65:  return 13;
      SRC_R55:  return 11;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    return VEC_W'(half_steps(idx) * 4);
  endfunction

endpackage

// File: rtl/intvec_edge_latch.sv
module intvec_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend_o
);

  logic prev_q;
  logic lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= din;
      if (clr || (LEVEL_QUAL && !din))
        lat_q <= 1'b0;
      else if (din && !prev_q)
        lat_q <= 1'b1;
    end
  end

  // Level-qualified variant needs the input still high to count.
  generate
    if (LEVEL_QUAL) begin : g_qual
      assign pend_o = lat_q & din;
    end else begin : g_plain
      assign pend_o = lat_q;
    end
  endgenerate

endmodule

// File: rtl/intvec_ctl_regs.sv
module intvec_ctl_regs
  import intvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] mask_wdata,
  input  logic              ei_cmd,
  input  logic              di_cmd,
  input  logic              instr_done,
  input  logic              accept,
  input  logic              stat_rd,
  input  logic              serial_in,
  input  logic              r75_pend,
  input  logic              lvl65,
  input  logic              lvl55,
  output logic [MASK_W-1:0] mask_q,
  output logic              ie_q,
  output logic              ie_eff,
  output logic              clr75,
  output logic              serial_out,
  output logic [WORD_W-1:0] status_o
);

  logic arm_q;
  logic unused_bits;

  assign unused_bits = mask_wdata[5];
  assign clr75       = mask_wr & mask_wdata[MW_CLR75];
  // The armed state lets the boundary after the enable command take a request.
  assign ie_eff      = ie_q | arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '1;
      serial_out <= 1'b0;
    end else if (mask_wr) begin
      if (mask_wdata[MW_MSE])
        mask_q <= mask_wdata[MASK_W-1:0];
      if (mask_wdata[MW_SDE])
        serial_out <= mask_wdata[MW_SDO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      arm_q <= 1'b0;
    end else if (accept || di_cmd) begin
      ie_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (arm_q && instr_done) begin
        ie_q  <= 1'b1;
        arm_q <= 1'b0;
      end
      if (ei_cmd)
        arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      status_o <= '0;
    else if (stat_rd)
      status_o <= {serial_in, r75_pend, lvl65, lvl55, ie_q, mask_q};
  end

endmodule

// File: rtl/intvec_arb.sv
module intvec_arb
  import intvec_pkg::*;
#(
  parameter int N       = NSRC,
  parameter int VW      = VEC_W,
  parameter int GEN_IDX = SRC_GEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic          instr_done,
  output logic [N-1:0]  grant,
  output logic          accept,
  output logic          take_o,
  output logic [VW-1:0] vector_o,
  output logic          vec_ext_o,
  output logic          inta_n_o
);

  logic [N-1:0]  higher;
  logic [VW-1:0] vec_n;

  // Fixed priority chain: index 0 highest.
  assign higher[0] = 1'b0;
  assign grant[0]  = pend[0];
  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_chain
      assign higher[gi] = higher[gi-1] | pend[gi-1];
      assign grant[gi]  = pend[gi] & ~higher[gi];
    end
  endgenerate

  assign accept = instr_done & (|pend);

  always_comb begin
    vec_n = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) vec_n = VW'(src_vector(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o    <= 1'b0;
      vector_o  <= '0;
      vec_ext_o <= 1'b0;
      inta_n_o  <= 1'b1;
    end else begin
      take_o   <= accept;
      inta_n_o <= ~(accept & grant[GEN_IDX]);
      if (accept) begin
        vector_o  <= vec_n;
        vec_ext_o <= grant[GEN_IDX];
      end
    end
  end

endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
  import intvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic              req75,
  input  logic              req65,
  input  logic              req55,
  input  logic              ext_req,
  input  logic              instr_done,
  input  logic              ei_cmd,
  input  logic              di_cmd,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] mask_wdata,
  input  logic              stat_rd,
  input  logic              serial_in,
  output logic              take_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              vec_ext_o,
  output logic              inta_n_o,
  output logic              serial_out_o,
  output logic [WORD_W-1:0] status_o
);

  logic              trap_pend;
  logic              r75_pend;
  logic [MASK_W-1:0] mask_q;
  logic              ie_q;
  logic              ie_eff;
  logic              clr75_wr;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   grant;
  logic              accept;

  intvec_edge_latch #(.LEVEL_QUAL(1'b1)) u_trap (
    .clk(clk), .rst(rst), .din(trap_req),
    .clr(accept & grant[SRC_TRAP]), .pend_o(trap_pend)
  );

  intvec_edge_latch #(.LEVEL_QUAL(1'b0)) u_r75 (
    .clk(clk), .rst(rst), .din(req75),
    .clr((accept & grant[SRC_R75]) | clr75_wr), .pend_o(r75_pend)
  );

  intvec_ctl_regs u_regs (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .instr_done(instr_done),
    .accept(accept), .stat_rd(stat_rd), .serial_in(serial_in),
    .r75_pend(r75_pend), .lvl65(req65), .lvl55(req55),
    .mask_q(mask_q), .ie_q(ie_q), .ie_eff(ie_eff), .clr75(clr75_wr),
    .serial_out(serial_out_o), .status_o(status_o)
  );

  assign pend[SRC_TRAP] = trap_pend;
  assign pend[SRC_R75]  = r75_pend & ~mask_q[2] & ie_eff;
  assign pend[SRC_R65]  = req65    & ~mask_q[1] & ie_eff;
  assign pend[SRC_R55]  = req55    & ~mask_q[0] & ie_eff;
  assign pend[SRC_GEN]  = ext_req  & ie_eff;

  intvec_arb u_arb (
    .clk(clk), .rst(rst), .pend(pend), .instr_done(instr_done),
    .grant(grant), .accept(accept), .take_o(take_o),
    .vector_o(vector_o), .vec_ext_o(vec_ext_o), .inta_n_o(inta_n_o)
  );

endmodule

// File: rtl/intvec_chk.sv
module intvec_chk (
  input logic        clk,
  input logic        rst,
  input logic        take,
  input logic        ext,
  input logic        inta_n,
  input logic [15:0] vec,
  input logic        sod,
  input logic        done,
  input logic        wr,
  input logic [7:0]  wdata,
  input logic        ie
);

  a_r10_take_one_cycle: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  a_r10_take_after_boundary: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(done));

  a_r9_ack_only_external: assert property (@(posedge clk) disable iff (rst)
    !inta_n |-> (take && ext));

  a_r9_external_strobes_ack: assert property (@(posedge clk) disable iff (rst)
    (take && ext) |-> (!inta_n && vec == 16'h0000));

  a_r8_accept_clears_enable: assert property (@(posedge clk) disable iff (rst)
    take |-> !ie);

  a_r1_vector_legal: assert property (@(posedge clk) disable iff (rst)
    (take && !ext) |-> (vec == 16'h0024 || vec == 16'h002C ||
                        vec == 16'h0034 || vec == 16'h003C));

  a_r11_sod_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr && wdata[7]) |=> $stable(sod));

endmodule

bind intvec_ctrl intvec_chk u_chk (
  .clk(clk), .rst(rst), .take(take_o), .ext(vec_ext_o), .inta_n(inta_n_o),
  .vec(vector_o), .sod(serial_out_o), .done(instr_done), .wr(mask_wr),
  .wdata(mask_wdata), .ie(ie_q)
);

// File: tb/tb_intvec_ctrl.sv
`timescale 1ns/1ps
module tb_intvec_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        trap_req, req75, req65, req55, ext_req;
  logic        instr_done, ei_cmd, di_cmd, mask_wr, stat_rd, serial_in;
  logic [7:0]  mask_wdata;
  logic        take_o, vec_ext_o, inta_n_o, serial_out_o;
  logic [15:0] vector_o;
  logic [7:0]  status_o;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  intvec_ctrl dut (
    .clk(clk), .rst(rst), .trap_req(trap_req), .req75(req75), .req65(req65),
    .req55(req55), .ext_req(ext_req), .instr_done(instr_done), .ei_cmd(ei_cmd),
    .di_cmd(di_cmd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .stat_rd(stat_rd), .serial_in(serial_in), .take_o(take_o),
    .vector_o(vector_o), .vec_ext_o(vec_ext_o), .inta_n_o(inta_n_o),
    .serial_out_o(serial_out_o), .status_o(status_o)
  );

  // {trap,r75,r65,r55,gen}[25:21], mask[20:18], take[17], ext[16], vector[15:0]
  localparam logic [25:0] TBL [12] = '{
    {5'b01000, 3'b000, 1'b1, 1'b0, 16'h003C},
    {5'b00100, 3'b000, 1'b1, 1'b0, 16'h0034},
    {5'b00010, 3'b000, 1'b1, 1'b0, 16'h002C},
    {5'b00001, 3'b000, 1'b1, 1'b1, 16'h0000},
    {5'b10000, 3'b111, 1'b1, 1'b0, 16'h0024},
    {5'b11111, 3'b000, 1'b1, 1'b0, 16'h0024},
    {5'b01111, 3'b000, 1'b1, 1'b0, 16'h003C},
    {5'b00111, 3'b000, 1'b1, 1'b0, 16'h0034},
    {5'b01110, 3'b100, 1'b1, 1'b0, 16'h0034},
    {5'b00110, 3'b010, 1'b1, 1'b0, 16'h002C},
    {5'b00011, 3'b001, 1'b1, 1'b1, 16'h0000},
    {5'b01110, 3'b111, 1'b0, 1'b0, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {trap_req, req75, req65, req55, ext_req} = '0;
    {instr_done, ei_cmd, di_cmd, mask_wr, stat_rd, serial_in} = '0;
    mask_wdata = '0;
    cyc(); cyc();
    rst = 1'b0;
    cyc();
  endtask

  task automatic mwrite(input logic [7:0] w);
    mask_wr = 1'b1; mask_wdata = w; cyc(); mask_wr = 1'b0; mask_wdata = '0;
  endtask

  task automatic ei();
    ei_cmd = 1'b1; instr_done = 1'b1; cyc(); ei_cmd = 1'b0; instr_done = 1'b0;
  endtask

  task automatic boundary();
    instr_done = 1'b1; cyc(); instr_done = 1'b0;
  endtask

  task automatic status_read();
    stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
  endtask

  initial begin
    do_reset();
    // Reset state
    check("R9 reset ack high", 32'(inta_n_o), 32'd1);
    check("R10 reset no take", 32'(take_o), 32'd0);
    check("R11 reset sod", 32'(serial_out_o), 32'd0);
    status_read();
    check("R12 R3 reset status", 32'(status_o), 32'h07);

    // Table walk: priority, masks, vectors
    for (int i = 0; i < 12; i++) begin
      logic [25:0] row;
      row = TBL[i];
      do_reset();
      mwrite(8'h08 | {5'b0, row[20:18]});
      ei();
      {trap_req, req75, req65, req55, ext_req} = row[25:21];
      cyc();
      boundary();
      check($sformatf("R2 R3 row%0d take", i), 32'(take_o), 32'(row[17]));
      if (row[17]) begin
        check($sformatf("R1 R2 row%0d vector", i), 32'(vector_o), 32'(row[15:0]));
        check($sformatf("R9 row%0d ext", i), 32'(vec_ext_o), 32'(row[16]));
        check($sformatf("R9 row%0d ack", i), 32'(inta_n_o), 32'(!row[16]));
      end
      cyc();
      check($sformatf("R10 row%0d pulse ends", i), 32'(take_o), 32'd0);
      check($sformatf("R9 row%0d ack released", i), 32'(inta_n_o), 32'd1);
      {trap_req, req75, req65, req55, ext_req} = '0;
    end

    // R7: enable delayed by one instruction
    do_reset();
    mwrite(8'h08);
    req55 = 1'b1;
    ei();
    check("R7 no take at enable boundary", 32'(take_o), 32'd0);
    boundary();
    check("R7 take at next boundary", 32'(take_o), 32'd1);
    check("R7 R1 vector 5.5", 32'(vector_o), 32'h002C);
    // R8: accept cleared enable
    boundary();
    check("R8 enable cleared by accept", 32'(take_o), 32'd0);
    ei();
    di_cmd = 1'b1; cyc(); di_cmd = 1'b0;
    boundary();
    check("R8 disable command", 32'(take_o), 32'd0);
    req55 = 1'b0;

    // R4 / R8: trap bypasses enable, edge plus level
    do_reset();
    trap_req = 1'b1; cyc();
    boundary();
    check("R8 trap without enable", 32'(take_o), 32'd1);
    check("R4 trap vector", 32'(vector_o), 32'h0024);
    cyc();
    boundary();
    check("R4 held trap not retaken", 32'(take_o), 32'd0);
    trap_req = 1'b0; cyc();
    trap_req = 1'b1; cyc();
    trap_req = 1'b0; cyc();
    boundary();
    check("R4 trap dropped before boundary", 32'(take_o), 32'd0);

    // R5: 7.5 latch
    do_reset();
    mwrite(8'h08);
    req75 = 1'b1; cyc(); req75 = 1'b0; cyc();
    ei();
    boundary();
    check("R5 latched 7.5 taken", 32'(take_o), 32'd1);
    check("R5 R1 vector 7.5", 32'(vector_o), 32'h003C);
    ei();
    boundary();
    check("R5 latch cleared by accept", 32'(take_o), 32'd0);
    req75 = 1'b1; cyc(); req75 = 1'b0; cyc();
    status_read();
    check("R12 latched 7.5 visible", 32'(status_o), 32'h48);
    mwrite(8'h10);
    status_read();
    check("R5 R3 clear bit, masks kept", 32'(status_o), 32'h08);
    boundary();
    check("R5 cleared latch not taken", 32'(take_o), 32'd0);

    // R6: level-sensitive 6.5
    do_reset();
    mwrite(8'h08);
    ei();
    req65 = 1'b1; cyc(); req65 = 1'b0;
    boundary();
    check("R6 dropped 6.5 ignored", 32'(take_o), 32'd0);

    // R11: serial output
    do_reset();
    mwrite(8'hC0);
    check("R11 sod set", 32'(serial_out_o), 32'd1);
    mwrite(8'h00);
    check("R11 sod held without enable bit", 32'(serial_out_o), 32'd1);
    mwrite(8'h80);
    check("R11 sod cleared", 32'(serial_out_o), 32'd0);

    // R12: status fields
    serial_in = 1'b1; req55 = 1'b1; req65 = 1'b1;
    status_read();
    check("R12 status fields", 32'(status_o), 32'hB7);
    serial_in = 1'b0; req55 = 1'b0; req65 = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule